// File: doc/BRIEF.md
# Memory Cycle Wait-State Generator

This block lengthens memory machine cycles of an 8-bit CPU by one clock so that slower memory outside the shared video region can keep up. It watches the CPU's memory request, opcode-fetch and refresh strobes on the CPU clock. When a qualifying memory cycle starts, it pulls the active-low WAIT line for one CPU clock and then releases it. It makes at most one decision per machine cycle.

A two-bit mode register, loaded through a simple write port, selects the policy: no waits at all, waits on opcode fetches only, or waits on every memory cycle. Accesses that the address decoder flags as falling in the shared video region get no wait from this block, because another mechanism already holds the CPU for those accesses. Refresh cycles and IO cycles never receive a wait. The pulse length in CPU clocks is a parameter, `WAIT_CYCLES`, which defaults to one.

Top module: `wait_state_gen`

## Requirements
- R1: After reset `wait_n` is high and the mode is disabled, so no memory cycle is lengthened until the mode register is written.
- R2: With mode code 00, `wait_n` stays high for every kind of memory cycle.
- R3: With mode code 01, a wait is inserted only when `m1_n` is low at the deciding edge. A memory cycle with `m1_n` high gets none.
- R4: With mode code 10 or 11, every qualifying memory cycle gets a wait, whether or not `m1_n` is low.
- R5: The deciding edge is the first rising clock edge at which `mreq_n` is sampled low. `wait_n` goes low right after that edge and stays low for exactly `WAIT_CYCLES` clocks (default 1), then returns high.
- R6: If `shared_hit` is high at the deciding edge, no wait is inserted.
- R7: If `rfsh_n` is low at the deciding edge, no wait is inserted.
- R8: Each low period of `mreq_n` has exactly one deciding edge, whether or not it produces a wait. The generator re-arms only after `mreq_n` has been sampled high at a rising edge, and then a following low period is decided afresh.
- R9: While `mreq_n` is high, which covers IO cycles, no wait is inserted whatever the other inputs are.
- R10: When `mode_we` is high at a rising edge, `mode_wdata` is loaded into the mode register at that edge. A memory cycle whose deciding edge is that same edge is judged by the old mode, and cycles decided at later edges use the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreq_n | input | 1 | CPU memory request, active low |
| m1_n | input | 1 | Opcode-fetch cycle marker, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| shared_hit | input | 1 | Decoder flag: the current address is in the shared video region |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 2 | Mode code: 00 off, 01 fetch only, 10/11 all memory |
| wait_n | output | 1 | Active-low WAIT to the CPU |

## Verification
The assertions assume that `m1_n`, `rfsh_n` and `shared_hit` are already valid at the edge where `mreq_n` is first sampled low. They also assume these inputs, like `mreq_n` and the mode write port, change only away from the rising clock edge, as a synchronous CPU bus would drive them. The bench follows both rules. It drives every input on the falling edge and sets the qualifiers in the same step that lowers `mreq_n`. It holds each request long enough that the one-clock pulse and the lack of any second pulse can both be seen before `mreq_n` rises.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        WM_OFF     = 2'b00,
        WM_FETCH   = 2'b01,
        WM_ALL     = 2'b10,
        WM_ALL_ALT = 2'b11
    } wmode_e;

    typedef struct packed {
        wmode_e mode;
    } mode_state_t;

    // Policy decision for one memory machine cycle.
    function automatic logic policy_wants_wait(
        input wmode_e mode,
        input logic   m1_n,
        input logic   rfsh_n,
        input logic   shared_hit
    );
        logic by_mode;
        case (mode)
            WM_OFF:   by_mode = 1'b0;
            WM_FETCH: by_mode = ~m1_n;
            default:  by_mode = 1'b1;
        endcase
        return by_mode & rfsh_n & ~shared_hit;
    endfunction

endpackage

// File: rtl/wsg_mode_reg.sv
module wsg_mode_reg
    import wsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output wmode_e            mode_o
);

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mode = wmode_e'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= WM_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    // R10: a write lands in the register at the edge it is presented
    assert_mode_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_o == wmode_e'($past(wr_data))));

endmodule

// File: rtl/wsg_qualify.sv
module wsg_qualify
    import wsg_pkg::*;
(
    input  wmode_e mode,
    input  logic   m1_n,
    input  logic   rfsh_n,
    input  logic   shared_hit,
    output logic   want_wait
);

    always_comb begin
        want_wait = policy_wants_wait(mode, m1_n, rfsh_n, shared_hit);
    end

endmodule

// File: rtl/wsg_pulse.sv
module wsg_pulse #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mreq_n,
    input  logic want_wait,
    output logic wait_active
);

    localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;

    typedef struct packed {
        logic             armed;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } pulse_state_t;

    pulse_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // running pulse: count down, drop when the last clock is done
        if (st_q.active) begin
            if (st_q.cnt == '0) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        // arming and the single decision per request
        if (mreq_n) begin
            st_d.armed = 1'b1;
        end else if (st_q.armed) begin
            st_d.armed = 1'b0;
            if (want_wait) begin
                st_d.active = 1'b1;
                st_d.cnt    = CNT_W'(WAIT_CYCLES - 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.armed  <= 1'b1;
            st_q.active <= 1'b0;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wait_active = st_q.active;

    // R8: a pulse only starts from the armed state
    assert_start_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(st_q.armed));

    // R9: no pulse starts while the request is inactive
    assert_no_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> !$past(mreq_n));

    generate
        if (WAIT_CYCLES == 1) begin : g_single
            // R5: a single-clock pulse never lasts a second clock
            assert_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.active |=> !st_q.active);
        end
    endgenerate

endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
    import wsg_pkg::*;
#(
    parameter int WAIT_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_n,
    input  logic              m1_n,
    input  logic              rfsh_n,
    input  logic              shared_hit,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic              wait_n
);

    wmode_e mode;
    logic   want_wait;
    logic   wait_active;

    wsg_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_we),
        .wr_data (mode_wdata),
        .mode_o  (mode)
    );

    wsg_qualify u_qual (
        .mode       (mode),
        .m1_n       (m1_n),
        .rfsh_n     (rfsh_n),
        .shared_hit (shared_hit),
        .want_wait  (want_wait)
    );

    wsg_pulse #(.WAIT_CYCLES(WAIT_CYCLES)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .mreq_n      (mreq_n),
        .want_wait   (want_wait),
        .wait_active (wait_active)
    );

    assign wait_n = ~wait_active;

    // R2: disabled mode never produces a wait
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> ($past(mode) != WM_OFF));

    // R3: fetch-only mode waits only on opcode fetches
    assert_fetch_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wait_n) && ($past(mode) == WM_FETCH)) |-> !$past(m1_n));

    // R6: shared-region accesses are left to the other stall mechanism
    assert_no_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> !$past(shared_hit));

    // R7: refresh cycles are never lengthened
    assert_no_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> $past(rfsh_n));

endmodule

// File: tb/sim_wait_state_gen.sv
module sim_wait_state_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mreq_n, m1_n, rfsh_n, shared_hit, mode_we;
    logic [1:0] mode_wdata;
    logic       wait_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    wait_state_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mreq_n     (mreq_n),
        .m1_n       (m1_n),
        .rfsh_n     (rfsh_n),
        .shared_hit (shared_hit),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .wait_n     (wait_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: wait_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic set_mode(input logic [1:0] code);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = code;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    // One memory request held three clocks; expects a single pulse or none.
    task automatic mem_cycle(input logic m1, input logic rf, input logic sh,
                             input logic expect_wait, input string tag);
        @(negedge clk);
        mreq_n = 1'b0; m1_n = m1; rfsh_n = rf; shared_hit = sh;
        @(negedge clk);
        check(wait_n, ~expect_wait, tag);
        @(negedge clk);
        check(wait_n, 1'b1, {tag, " release R5"});
        @(negedge clk);
        check(wait_n, 1'b1, {tag, " single R8"});
        mreq_n = 1'b1; m1_n = 1'b1; rfsh_n = 1'b1; shared_hit = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(wait_n, 1'b1, "R1 reset level");
        mem_cycle(1'b0, 1'b1, 1'b0, 1'b0, "R1 no wait before mode write");
    endtask

    task automatic t_off;
        set_mode(2'b00);
        mem_cycle(1'b0, 1'b1, 1'b0, 1'b0, "R2 off fetch");
        mem_cycle(1'b1, 1'b1, 1'b0, 1'b0, "R2 off data");
    endtask

    task automatic t_fetch;
        set_mode(2'b01);
        mem_cycle(1'b0, 1'b1, 1'b0, 1'b1, "R3 fetch waits");
        mem_cycle(1'b1, 1'b1, 1'b0, 1'b0, "R3 data no wait");
    endtask

    task automatic t_all;
        set_mode(2'b10);
        mem_cycle(1'b1, 1'b1, 1'b0, 1'b1, "R4 code10 data");
        mem_cycle(1'b0, 1'b1, 1'b0, 1'b1, "R4 code10 fetch");
        set_mode(2'b11);
        mem_cycle(1'b1, 1'b1, 1'b0, 1'b1, "R4 code11 data");
    endtask

    task automatic t_exclusions;
        set_mode(2'b10);
        mem_cycle(1'b1, 1'b1, 1'b1, 1'b0, "R6 shared data");
        mem_cycle(1'b0, 1'b1, 1'b1, 1'b0, "R6 shared fetch");
        mem_cycle(1'b1, 1'b0, 1'b0, 1'b0, "R7 refresh");
    endtask

    task automatic t_io;
        set_mode(2'b11);
        @(negedge clk);
        mreq_n = 1'b1; m1_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(wait_n, 1'b1, "R9 idle request no wait");
        end
        m1_n = 1'b1;
    endtask

    task automatic t_rearm;
        set_mode(2'b10);
        // back-to-back requests separated by a single high clock
        @(negedge clk);
        mreq_n = 1'b0;
        @(negedge clk);
        check(wait_n, 1'b0, "R8 first request waits");
        @(negedge clk);
        mreq_n = 1'b1;
        check(wait_n, 1'b1, "R5 first released");
        @(negedge clk);
        mreq_n = 1'b0;
        @(negedge clk);
        check(wait_n, 1'b0, "R8 re-armed request waits");
        // long request: only one pulse in six clocks
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(wait_n, 1'b1, "R8 long request single pulse");
        end
        mreq_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_mode_timing;
        set_mode(2'b00);
        // write and deciding edge coincide: old mode (off) applies
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = 2'b10; mreq_n = 1'b0;
        @(negedge clk);
        mode_we = 1'b0;
        check(wait_n, 1'b1, "R10 same-edge uses old mode");
        mreq_n = 1'b1;
        @(negedge clk);
        mem_cycle(1'b1, 1'b1, 1'b0, 1'b1, "R10 new mode applies");
    endtask

    initial begin
        rst_n = 1'b0; mreq_n = 1'b1; m1_n = 1'b1; rfsh_n = 1'b1;
        shared_hit = 1'b0; mode_we = 1'b0; mode_wdata = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_fetch();
        t_all();
        t_exclusions();
        t_io();
        t_rearm();
        t_mode_timing();
        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
        end
    end

endmodule